// File: doc/BRIEF.md
# Third-Order Comb-Integrator Decimator with Word Formatter

This block turns a one-bit oversampled bit stream into two's-complement words at one thirty-second of the input rate. Each input bit counts as +1 or −1. The filter is a third-order comb-integrator filter with a decimation ratio of 32. Three running-sum stages advance on every qualified input bit. Three difference stages fire once per output word. The filter output carries one bit more than is needed, so it is halved. The halved value is then limited to a 15-bit signed range.

A formatter then prepares each word for a serial link, in one of two layouts.
- **16-bit data layout:** the 15-bit value is left-justified and a 0 is placed in the LSB. A positive full-scale input is the one exception: it yields exactly 0x7FFF.
- **Mixed layout:** the 15-bit value sits in the low bits, and the MSB is a flag that marks the word as data.

A one-clock strobe marks each new word.

Top module: `sinc3_decim`

## Requirements
- R1: One word is produced for every 32 clock cycles in which `bit_en_i` is high, counted from reset. Cycles with `bit_en_i` low do not advance the filter and do not change its state. `word_valid_o` rises on the clock edge that takes the 32nd qualified bit.
- R2: `word_valid_o` is high for exactly one clock per word and is low at all other times.
- R3: Let y be the convolution of the mapped input (+1 for a 1, −1 for a 0, and 0 for samples before reset) with the 94-tap impulse response of ((1 − z^-32)/(1 − z^-1))^3, taken up to and including the bit that completes the word. The raw result is y/2, which always lies in [−16384, +16384].
- R4: The raw result is limited to the 15-bit signed range [−16384, +16383] before it is formatted.
- R5: When `mixed_mode_i` is 0, the word is the limited 15-bit value in bits [15:1], with bit 0 equal to 0.
- R6: When `mixed_mode_i` is 0 and the raw result is above +16383 (full-scale positive input), the word is exactly 0x7FFF.
- R7: When `mixed_mode_i` is 1, the word is the limited 15-bit value in bits [14:0], with bit 15 equal to 0, which is the data flag.
- R8: While `rst_n` is low at a rising clock edge, all filter state, the phase count, `word_o` and `word_valid_o` are cleared to 0.
- R9: The layout of a word is chosen by the value of `mixed_mode_i` in the cycle that takes the 32nd qualified bit. Its value in earlier cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en_i | input | 1 | Marks a cycle that carries a stream bit |
| bit_i | input | 1 | Oversampled stream bit (1 counts as +1, 0 as −1) |
| mixed_mode_i | input | 1 | 0 selects the 16-bit data layout, 1 selects the flagged 15-bit layout |
| word_o | output | 16 | Formatted decimated word |
| word_valid_o | output | 1 | One-clock strobe for a new word |

## Verification
The hardest case to reach is the positive-limit path. It needs a full 94-bit window of ones since the last reset, so that the raw result reaches +16384 and the 0x7FFF substitution takes place. Random stimulus almost never produces this. Directed runs of all-ones and all-zeros therefore drive the filter to both rails, in each layout. The mode is flipped on the very cycle of the 32nd bit to show that only that cycle's value counts. Long random runs with sparse enables compare every word against a 94-tap convolution that the bench builds from three 32-sample boxcars.

// File: rtl/sinc3_pkg.sv
// Shared types for the third-order decimator.
// Assumes: one formatter mode bit; the data flag value is fixed here.
package sinc3_pkg;
    typedef enum logic {
        FMT_DATA16 = 1'b0,
        FMT_MIXED  = 1'b1
    } fmt_mode_e;

    // MSB value that marks a word as data in the mixed layout.
    localparam logic DATA_FLAG = 1'b0;
endpackage

// File: rtl/sinc3_integ.sv
// Running-sum chain of the comb-integrator filter.
// Each stage adds the output of the stage before it, computed in the same cycle,
// so sum_o already includes the current bit. Arithmetic wraps at ACC_W bits;
// later difference stages cancel the wrap.
// Assumes: step_i qualifies bit_i; state only moves when step_i is high.
module sinc3_integ #(
    parameter int ORDER = 3,
    parameter int ACC_W = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_i,
    input  logic                    bit_i,
    output logic signed [ACC_W-1:0] sum_o
);
    logic signed [ACC_W-1:0] x_val;
    logic signed [ACC_W-1:0] acc_q [ORDER];
    logic signed [ACC_W-1:0] nxt   [ORDER];

    // Map the stream bit to +1 or -1.
    always_comb x_val = bit_i ? ACC_W'(1) : '1;

    for (genvar s = 0; s < ORDER; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign nxt[s] = acc_q[s] + x_val;
        end else begin : g_rest
            assign nxt[s] = acc_q[s] + nxt[s-1];
        end

        // Advance this running sum on each qualified bit.
        always_ff @(posedge clk) begin
            if (!rst_n)      acc_q[s] <= '0;
            else if (step_i) acc_q[s] <= nxt[s];
        end
    end

    assign sum_o = nxt[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
// Difference chain of the comb-integrator filter, working at the decimated rate.
// On take_i, each stage stores its input for use with the next word.
// dout_o is combinational and valid in the take_i cycle.
// Assumes: take_i is high once every decimation period.
module sinc3_comb #(
    parameter int ORDER     = 3,
    parameter int ACC_W     = 17,
    parameter int GAIN_LOG2 = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take_i,
    input  logic signed [ACC_W-1:0] din_i,
    output logic signed [ACC_W-1:0] dout_o
);
    localparam logic signed [ACC_W-1:0] PEAK = ACC_W'(1) <<< GAIN_LOG2;

    logic signed [ACC_W-1:0] dly_q [ORDER];
    logic signed [ACC_W-1:0] diff  [ORDER];

    for (genvar s = 0; s < ORDER; s++) begin : g_stage
        if (s == 0) begin : g_first
            assign diff[s] = din_i - dly_q[s];
            // Hold the integrator value seen at this decimation point.
            always_ff @(posedge clk) begin
                if (!rst_n)      dly_q[s] <= '0;
                else if (take_i) dly_q[s] <= din_i;
            end
        end else begin : g_rest
            assign diff[s] = diff[s-1] - dly_q[s];
            // Hold the previous stage's difference for the next word.
            always_ff @(posedge clk) begin
                if (!rst_n)      dly_q[s] <= '0;
                else if (take_i) dly_q[s] <= diff[s-1];
            end
        end
    end

    assign dout_o = diff[ORDER-1];

    // R3
    cic_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (dout_o <= PEAK) && (dout_o >= -PEAK));
endmodule

// File: rtl/sinc3_fmt.sv
// Limits the raw filter value to PAY_W signed bits and lays it out.
// Data layout: value in the upper bits, 0 in the LSB, and all ones below the MSB
// at the positive limit. Mixed layout: the data flag in the MSB above the value.
// Assumes: raw_i is already halved; purely combinational.
module sinc3_fmt
    import sinc3_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic signed [OUT_W-1:0] raw_i,
    input  fmt_mode_e               mode_i,
    output logic        [OUT_W-1:0] word_o
);
    localparam int PAY_W = OUT_W - 1;
    localparam logic signed [OUT_W-1:0] POS_LIM = OUT_W'((1 << (PAY_W - 1)) - 1);
    localparam logic signed [OUT_W-1:0] NEG_LIM = ~POS_LIM;

    logic             sat_pos;
    logic             sat_neg;
    logic [PAY_W-1:0] clipped;

    // Clip to the payload range and build the output word.
    always_comb begin
        sat_pos = raw_i > POS_LIM;
        sat_neg = raw_i < NEG_LIM;
        if (sat_pos)      clipped = POS_LIM[PAY_W-1:0];
        else if (sat_neg) clipped = NEG_LIM[PAY_W-1:0];
        else              clipped = raw_i[PAY_W-1:0];

        if (mode_i == FMT_MIXED) word_o = {DATA_FLAG, clipped};
        else if (sat_pos)        word_o = {1'b0, {PAY_W{1'b1}}};
        else                     word_o = {clipped, 1'b0};
    end
endmodule

// File: rtl/sinc3_decim.sv
// Top level: third-order comb-integrator decimator, ratio DEC_RATIO, plus formatter.
// A phase count of qualified bits decides when the difference stages fire.
// The formatted word and a one-clock strobe are registered on that edge.
// Assumes: DEC_RATIO is a power of two, and ORDER*log2(DEC_RATIO) equals OUT_W-1,
// so that the halved filter value fits OUT_W bits.
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int DEC_RATIO = 32,
    parameter int ORDER     = 3,
    parameter int OUT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en_i,
    input  logic             bit_i,
    input  logic             mixed_mode_i,
    output logic [OUT_W-1:0] word_o,
    output logic             word_valid_o
);
    localparam int PH_W      = $clog2(DEC_RATIO);
    localparam int GAIN_LOG2 = ORDER * PH_W;
    localparam int ACC_W     = GAIN_LOG2 + 2;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DEC_RATIO - 1);

    logic [PH_W-1:0]         phase_q;
    logic                    take;
    logic signed [ACC_W-1:0] integ_sum;
    logic signed [ACC_W-1:0] cic_out;
    logic [OUT_W-1:0]        fmt_word;
    logic [OUT_W-1:0]        word_q;
    logic                    valid_q;

    assign take = bit_en_i && (phase_q == PH_LAST);

    // Count qualified bits within the current decimation period.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= '0;
        else if (take)     phase_q <= '0;
        else if (bit_en_i) phase_q <= phase_q + PH_W'(1);
    end

    sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (bit_en_i),
        .bit_i  (bit_i),
        .sum_o  (integ_sum)
    );

    sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W), .GAIN_LOG2(GAIN_LOG2)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .din_i  (integ_sum),
        .dout_o (cic_out)
    );

    sinc3_fmt #(.OUT_W(OUT_W)) u_fmt (
        .raw_i  (cic_out[ACC_W-1:1]),
        .mode_i (fmt_mode_e'(mixed_mode_i)),
        .word_o (fmt_word)
    );

    // Register the formatted word and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) word_q <= fmt_word;
        end
    end

    assign word_o       = word_q;
    assign word_valid_o = valid_q;

    // R3
    cic_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !cic_out[0]);

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    // R1
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> $past(bit_en_i) && ($past(phase_q) == PH_LAST));

    // R5
    data_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o && !$past(mixed_mode_i) |->
            (word_o[0] == 1'b0) || (word_o == {1'b0, {(OUT_W-1){1'b1}}}));

    // R7
    mixed_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o && $past(mixed_mode_i) |-> word_o[OUT_W-1] == DATA_FLAG);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !word_valid_o && (word_o == '0));
endmodule

// File: tb/sinc3_decim_tb.sv
// Self-checking bench: directed rails and mode flips plus seeded random streams,
// each word compared with a convolution model built from three boxcars.
module sinc3_decim_tb;
    localparam int NTAP = 94;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        mixed_mode_i = 1'b0;
    logic [15:0] word_o;
    logic        word_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int taps [NTAP];
    int hist [NTAP];
    int n_seen = 0;

    always #2 clk = ~clk;

    sinc3_decim u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en_i     (bit_en_i),
        .bit_i        (bit_i),
        .mixed_mode_i (mixed_mode_i),
        .word_o       (word_o),
        .word_valid_o (word_valid_o)
    );

    // Expected word from the filter sum y and the layout bit.
    function automatic logic [15:0] exp_word(int y, bit mixed);
        int raw = y >>> 1;
        int p   = (raw > 16383) ? 16383 : ((raw < -16384) ? -16384 : raw);
        logic [14:0] pay = p[14:0];
        if (mixed)           return {1'b0, pay};
        else if (raw > 16383) return 16'h7FFF;
        else                  return {pay, 1'b0};
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en_i = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        // R8
        check(word_valid_o == 1'b0, "R8 valid", int'(word_valid_o), 0);
        check(word_o == 16'h0, "R8 word", int'(word_o), 0);
        for (int k = 0; k < NTAP; k++) hist[k] = 0;
        n_seen = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cycle(bit en, bit b, bit mixed, string tag);
        bit ev;
        int y;
        @(negedge clk);
        bit_en_i = en; bit_i = b; mixed_mode_i = mixed;
        @(posedge clk); #1;
        if (en) begin
            for (int k = NTAP - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = b ? 1 : -1;
            n_seen++;
        end
        ev = en && (n_seen % 32 == 0);
        // R1 timing of the strobe, R2 no strobe elsewhere
        check(word_valid_o == ev, ev ? "R1 strobe" : "R2 strobe",
              int'(word_valid_o), int'(ev));
        if (ev) begin
            logic [15:0] e;
            y = 0;
            for (int k = 0; k < NTAP; k++) y += taps[k] * hist[k];
            e = exp_word(y, mixed);
            if ((y >>> 1) > 16383)
                check(word_o == e, mixed ? "R4 limit" : "R6 fullscale", int'(word_o), int'(e));
            else
                check(word_o == e, tag, int'(word_o), int'(e));
        end
    endtask

    initial begin
        int a [NTAP];
        int b [NTAP];
        void'($urandom(32'd7321));
        for (int n = 0; n < NTAP; n++) a[n] = (n < 32) ? 1 : 0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int n = 0; n < NTAP; n++) begin
                b[n] = 0;
                for (int j = 0; j < 32; j++) if (n - j >= 0) b[n] += a[n-j];
            end
            for (int n = 0; n < NTAP; n++) a[n] = b[n];
        end
        for (int n = 0; n < NTAP; n++) taps[n] = a[n];

        do_reset();
        // positive rail, data layout then mixed layout
        for (int i = 0; i < 32 * 5; i++) cycle(1'b1, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 32 * 2; i++) cycle(1'b1, 1'b1, 1'b1, "R4");
        // negative rail in both layouts
        for (int i = 0; i < 32 * 4; i++) cycle(1'b1, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 32 * 2; i++) cycle(1'b1, 1'b0, 1'b1, "R7");
        // alternating bits settle to zero
        for (int i = 0; i < 32 * 4; i++) cycle(1'b1, i[0], 1'b0, "R5");
        // R9: mode held one way for 31 bits, other way on the 32nd
        for (int w = 0; w < 4; w++) begin
            for (int i = 0; i < 31; i++) cycle(1'b1, 1'($urandom), w[0], "R9");
            cycle(1'b1, 1'($urandom), ~w[0], "R9");
        end
        // gaps with toggling data must not move the filter (R1)
        for (int i = 0; i < 32 * 6; i++) begin
            cycle(1'b0, 1'($urandom), 1'($urandom), "R1");
            cycle(1'b1, 1'b1, 1'b0, "R1");
        end
        // seeded random stream with random enables and layouts
        for (int i = 0; i < 8000; i++)
            cycle(($urandom % 4) != 0, 1'($urandom), 1'($urandom), "R3");
        // reset in mid word, then restart
        for (int i = 0; i < 17; i++) cycle(1'b1, 1'b1, 1'b0, "R3");
        do_reset();
        for (int i = 0; i < 32 * 4; i++) cycle(1'b1, ($urandom % 8) != 0, 1'b0, "R3");
        for (int i = 0; i < 2000; i++)
            cycle(($urandom % 3) == 0, ($urandom % 5) != 0, 1'($urandom), "R7");

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule